// File: doc/BRIEF.md
# Data Store Path Controller

This block takes one processor data store whose physical address, bufferable attribute and cache lookup result are already known, and sends it to where it belongs. If the cache lookup hit, the store is merged into the word that was read out of the hit line. The merge picks its byte lanes according to the store size and the endian select. The merged word goes back with its word index and a flag that names which half of the line has become dirty.

If the lookup missed, the page's bufferable attribute decides the path. A bufferable page with the write buffer switched on gets a one-cycle push into the write buffer. A bufferable page with the buffer switched off gets a direct memory write. A non-bufferable page first asks the write buffer to drain completely and only then issues the direct memory write. Memory writes use a valid/ready handshake. New stores are held off while a drain or a memory write is outstanding.

When alignment checking is enabled and a store has a nonzero low address bit, the store is rejected with a fault pulse and nothing is written anywhere.

Top module: `store_path_ctrl`

## Requirements
- R1: When `align_chk_en` is 1 and `st_addr[1:0]` is nonzero, an accepted store gives `align_fault` high for exactly the one cycle after acceptance. It produces no cache write, no write-buffer push, no drain request and no memory request. When checking is off, the store is handled with its address rounded down to a word boundary.
- R2: A word store (`st_size` 2, or 3 which is treated as a word) that hits gives `cache_wr_en` high in the cycle after acceptance. In that cycle `cache_wr_data` equals `st_data` and `cache_wr_idx` equals `st_addr[IDX+1:2]`.
- R3: A halfword store (`st_size` 1) that hits replaces the 16 bits of `hit_word` at bit offset ((`st_bigend` ? 2 : 0) XOR (`st_addr` & 2)) × 8 with `st_data[15:0]` and keeps all other bits.
- R4: A byte store (`st_size` 0) that hits replaces the 8 bits of `hit_word` at bit offset ((`st_bigend` ? 3 : 0) XOR `st_addr[1:0]`) × 8 with `st_data[7:0]` and keeps all other bits.
- R5: Alongside each cache write, exactly one of `cache_dirty_first` (word index below LINE_WORDS/2) and `cache_dirty_last` (all other indices) is high. Both are low in every other cycle.
- R6: A miss with `st_bufferable` = 1 and `wb_enable` = 1 pulses `wb_push` for one cycle after acceptance and makes no memory request. `wb_bytes` is 4, 2 or 1 for word, halfword or byte. `wb_addr` is the word-aligned address; for a halfword it is ORed with `st_addr` bit 1, and for a byte with `st_addr[1:0]`. `wb_data` is `st_data`.
- R7: A miss with `st_bufferable` = 1 and `wb_enable` = 0 raises `mem_valid` in the cycle after acceptance, with no drain request. `mem_addr` follows the same sub-word rule as R6, `mem_data` is `st_data`, and `mem_size` is 0/1/2 for byte, halfword or word. These values hold until the first cycle in which `mem_ready` is sampled high, and `mem_valid` is low after that cycle.
- R8: A miss with `st_bufferable` = 0 raises `wb_drain_req` in the cycle after acceptance and keeps it high until `wb_empty` is sampled high. `mem_valid` rises only on that edge, and then behaves as in R7.
- R9: `st_ready` is low while a drain or memory write is outstanding and high otherwise. A store is taken only in a cycle with `st_valid` and `st_ready` both high.
- R10: After reset every output is low except `st_ready`, which is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store presented |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Physical store address, not truncated |
| st_data | input | 32 | Store data, right-justified |
| st_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| st_bigend | input | 1 | 1 selects big-endian lane placement |
| st_bufferable | input | 1 | Page is bufferable |
| wb_enable | input | 1 | Write buffer switched on |
| align_chk_en | input | 1 | Alignment checking enabled |
| cache_hit | input | 1 | Cache lookup hit for this store |
| hit_word | input | 32 | Current content of the addressed word in the hit line |
| align_fault | output | 1 | Alignment fault pulse |
| cache_wr_en | output | 1 | Cache word write pulse |
| cache_wr_idx | output | log2(LINE_WORDS) | Word index inside the line |
| cache_wr_data | output | 32 | Merged word |
| cache_dirty_first | output | 1 | Mark first half of line dirty |
| cache_dirty_last | output | 1 | Mark last half of line dirty |
| wb_push | output | 1 | Write-buffer push pulse |
| wb_addr | output | ADDR_W | Write-buffer entry address |
| wb_data | output | 32 | Write-buffer entry data |
| wb_bytes | output | 3 | Entry length in bytes: 4, 2 or 1 |
| wb_drain_req | output | 1 | Request that the write buffer empty itself |
| wb_empty | input | 1 | Write buffer holds nothing |
| mem_valid | output | 1 | Direct memory write request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | 32 | Memory write data |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |

## Verification
The assertions assume that the memory side raises `mem_ready` only as a response to a live request. They also assume that the write buffer's `wb_empty` is a plain level the controller may sample in any cycle, and that `cache_hit` and `hit_word` are valid in the cycle a store is taken. The stimulus drives every input away from the clock edge and changes store fields only while presenting a store. It toggles `mem_ready` and `wb_empty` freely, because the design must tolerate any pattern on them. Directed steps hold these two levels still so that drain and handshake stalls can be seen over several cycles.

// File: rtl/store_path_pkg.sv
package store_path_pkg;
  localparam int WORD_BYTES = 4;
  localparam int DATA_W     = 8 * WORD_BYTES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } st_size_e;

  typedef enum logic [1:0] {
    RT_IDLE  = 2'd0,
    RT_DRAIN = 2'd1,
    RT_MEM   = 2'd2
  } route_state_e;
endpackage

// File: rtl/store_lane_merge.sv
module store_lane_merge
  import store_path_pkg::*;
(
  input  logic [DATA_W-1:0]     old_word,
  input  logic [DATA_W-1:0]     new_data,
  input  logic [1:0]            size,
  input  logic                  bigend,
  input  logic [1:0]            lo,
  output logic [DATA_W-1:0]     merged,
  output logic [WORD_BYTES-1:0] lane_en
);
  logic [1:0] byte_lane;
  logic       half_hi;

  assign byte_lane = {bigend, bigend} ^ lo;
  assign half_hi   = bigend ^ lo[1];

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    localparam logic [1:0] LANE = b[1:0];
    logic [7:0] src;
    always_comb begin
      case (st_size_e'(size))
        SZ_BYTE: begin
          lane_en[b] = (LANE == byte_lane);
          src        = new_data[7:0];
        end
        SZ_HALF: begin
          lane_en[b] = (LANE[1] == half_hi);
          src        = new_data[8*(b%2) +: 8];
        end
        default: begin
          lane_en[b] = 1'b1;
          src        = new_data[8*b +: 8];
        end
      endcase
    end
    assign merged[8*b +: 8] = lane_en[b] ? src : old_word[8*b +: 8];
  end
endmodule

// File: rtl/store_half_dirty.sv
module store_half_dirty #(
  parameter int LINE_WORDS = 8
) (
  input  logic [$clog2(LINE_WORDS)-1:0] idx,
  output logic                          first_half,
  output logic                          last_half
);
  localparam int HALF = LINE_WORDS / 2;

  assign first_half = (int'(idx) < HALF);
  assign last_half  = !first_half;
endmodule

// File: rtl/store_route_fsm.sv
module store_route_fsm
  import store_path_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              bufferable,
  input  logic              wb_on,
  input  logic [ADDR_W-1:0] sub_addr,
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        size,
  input  logic              wb_empty,
  input  logic              mem_ready,
  output logic              idle,
  output logic              wb_push,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic [2:0]        wb_bytes,
  output logic              wb_drain_req,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [1:0]        mem_size
);
  route_state_e state;
  logic [2:0]   nbytes;
  logic [1:0]   norm_size;

  always_comb begin
    case (st_size_e'(size))
      SZ_BYTE: begin nbytes = 3'd1; norm_size = 2'd0; end
      SZ_HALF: begin nbytes = 3'd2; norm_size = 2'd1; end
      default: begin nbytes = 3'd4; norm_size = 2'd2; end
    endcase
  end

  assign idle = (state == RT_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= RT_IDLE;
      wb_push      <= 1'b0;
      wb_addr      <= '0;
      wb_data      <= '0;
      wb_bytes     <= '0;
      wb_drain_req <= 1'b0;
      mem_valid    <= 1'b0;
      mem_addr     <= '0;
      mem_data     <= '0;
      mem_size     <= '0;
    end else begin
      wb_push <= 1'b0;
      case (state)
        RT_IDLE: begin
          if (go) begin
            if (bufferable && wb_on) begin
              wb_push  <= 1'b1;
              wb_addr  <= sub_addr;
              wb_data  <= data;
              wb_bytes <= nbytes;
            end else begin
              mem_addr <= sub_addr;
              mem_data <= data;
              mem_size <= norm_size;
              if (bufferable) begin
                mem_valid <= 1'b1;
                state     <= RT_MEM;
              end else begin
                wb_drain_req <= 1'b1;
                state        <= RT_DRAIN;
              end
            end
          end
        end
        RT_DRAIN: begin
          if (wb_empty) begin
            wb_drain_req <= 1'b0;
            mem_valid    <= 1'b1;
            state        <= RT_MEM;
          end
        end
        RT_MEM: begin
          if (mem_ready) begin
            mem_valid <= 1'b0;
            state     <= RT_IDLE;
          end
        end
        default: state <= RT_IDLE;
      endcase
    end
  end

  // R8: memory request after a drain only once the buffer was seen empty
  a_r8_drain_gate: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_valid) && $past(wb_drain_req)) |-> $past(wb_empty));

  // R8: drain request persists while the buffer still holds data
  a_r8_drain_hold: assert property (@(posedge clk) disable iff (rst)
    (wb_drain_req && !wb_empty) |=> wb_drain_req);

  // R7: request fields stay put while memory stalls
  a_r7_req_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                   && $stable(mem_data) && $stable(mem_size)));

  // R9: a drain and a memory request never overlap
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(wb_drain_req && mem_valid));
endmodule

// File: rtl/store_path_ctrl.sv
module store_path_ctrl
  import store_path_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          st_valid,
  output logic                          st_ready,
  input  logic [ADDR_W-1:0]             st_addr,
  input  logic [31:0]                   st_data,
  input  logic [1:0]                    st_size,
  input  logic                          st_bigend,
  input  logic                          st_bufferable,
  input  logic                          wb_enable,
  input  logic                          align_chk_en,
  input  logic                          cache_hit,
  input  logic [31:0]                   hit_word,
  output logic                          align_fault,
  output logic                          cache_wr_en,
  output logic [$clog2(LINE_WORDS)-1:0] cache_wr_idx,
  output logic [31:0]                   cache_wr_data,
  output logic                          cache_dirty_first,
  output logic                          cache_dirty_last,
  output logic                          wb_push,
  output logic [ADDR_W-1:0]             wb_addr,
  output logic [31:0]                   wb_data,
  output logic [2:0]                    wb_bytes,
  output logic                          wb_drain_req,
  input  logic                          wb_empty,
  output logic                          mem_valid,
  input  logic                          mem_ready,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [31:0]                   mem_data,
  output logic [1:0]                    mem_size
);
  localparam int IDX_W = $clog2(LINE_WORDS);

  logic                  accept, misaligned, hit_go, route_go, idle;
  logic [1:0]            sub_lo;
  logic [ADDR_W-1:0]     sub_addr;
  logic [IDX_W-1:0]      idx;
  logic [DATA_W-1:0]     merged;
  logic [WORD_BYTES-1:0] lane_en;
  logic                  first_half, last_half;

  assign st_ready   = idle;
  assign accept     = st_valid && st_ready;
  assign misaligned = align_chk_en && (st_addr[1:0] != 2'b00);
  assign hit_go     = accept && !misaligned && cache_hit;
  assign route_go   = accept && !misaligned && !cache_hit;
  assign idx        = st_addr[IDX_W+1:2];

  always_comb begin
    case (st_size_e'(st_size))
      SZ_BYTE: sub_lo = st_addr[1:0];
      SZ_HALF: sub_lo = {st_addr[1], 1'b0};
      default: sub_lo = 2'b00;
    endcase
  end
  assign sub_addr = {st_addr[ADDR_W-1:2], sub_lo};

  store_lane_merge u_merge (
    .old_word (hit_word),
    .new_data (st_data),
    .size     (st_size),
    .bigend   (st_bigend),
    .lo       (st_addr[1:0]),
    .merged   (merged),
    .lane_en  (lane_en)
  );

  store_half_dirty #(.LINE_WORDS(LINE_WORDS)) u_dirty (
    .idx        (idx),
    .first_half (first_half),
    .last_half  (last_half)
  );

  store_route_fsm #(.ADDR_W(ADDR_W)) u_route (
    .clk          (clk),
    .rst          (rst),
    .go           (route_go),
    .bufferable   (st_bufferable),
    .wb_on        (wb_enable),
    .sub_addr     (sub_addr),
    .data         (st_data),
    .size         (st_size),
    .wb_empty     (wb_empty),
    .mem_ready    (mem_ready),
    .idle         (idle),
    .wb_push      (wb_push),
    .wb_addr      (wb_addr),
    .wb_data      (wb_data),
    .wb_bytes     (wb_bytes),
    .wb_drain_req (wb_drain_req),
    .mem_valid    (mem_valid),
    .mem_addr     (mem_addr),
    .mem_data     (mem_data),
    .mem_size     (mem_size)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      align_fault       <= 1'b0;
      cache_wr_en       <= 1'b0;
      cache_wr_idx      <= '0;
      cache_wr_data     <= '0;
      cache_dirty_first <= 1'b0;
      cache_dirty_last  <= 1'b0;
    end else begin
      align_fault       <= accept && misaligned;
      cache_wr_en       <= hit_go;
      cache_dirty_first <= hit_go && first_half;
      cache_dirty_last  <= hit_go && last_half;
      if (hit_go) begin
        cache_wr_idx  <= idx;
        cache_wr_data <= merged;
      end
    end
  end

  // R1: a faulting store leaves no trace on any write path
  a_r1_fault_silent: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> (!cache_wr_en && !wb_push && !$rose(mem_valid)
                     && !$rose(wb_drain_req)));

  // R5: exactly one half marked with each cache write
  a_r5_one_half: assert property (@(posedge clk) disable iff (rst)
    cache_wr_en |-> ($countones({cache_dirty_first, cache_dirty_last}) == 1));

  // R5: no dirty marking without a cache write
  a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
    !cache_wr_en |-> (!cache_dirty_first && !cache_dirty_last));

  // R3 and R4: number of replaced lanes matches the store size
  a_r4_lane_count: assert property (@(posedge clk) disable iff (rst)
    hit_go |-> ($countones(lane_en) ==
                ((st_size == 2'd0) ? 1 : (st_size == 2'd1) ? 2 : 4)));

  // R9: no store taken while busy
  a_r9_busy_block: assert property (@(posedge clk) disable iff (rst)
    (mem_valid || wb_drain_req) |-> !st_ready);
endmodule

// File: tb/store_path_ctrl_tb_top.sv
module store_path_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        st_valid = 0, st_bigend = 0, st_bufferable = 0, wb_enable = 0;
  logic        align_chk_en = 0, cache_hit = 0;
  logic [31:0] st_addr = 0, st_data = 0, hit_word = 0;
  logic [1:0]  st_size = 0;
  logic        st_ready, align_fault, cache_wr_en, cache_dirty_first, cache_dirty_last;
  logic [2:0]  cache_wr_idx, wb_bytes;
  logic [31:0] cache_wr_data, wb_addr, wb_data, mem_addr, mem_data;
  logic        wb_push, wb_drain_req, mem_valid;
  logic [1:0]  mem_size;
  logic        auto_hs = 0, man_mr = 1, man_we = 1, pat_mr = 0, pat_we = 0;
  logic        wb_empty, mem_ready;
  int          cyc = 0;
  assign mem_ready = auto_hs ? pat_mr : man_mr;
  assign wb_empty  = auto_hs ? pat_we : man_we;

  store_path_ctrl dut_i (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_size(st_size),
    .st_bigend(st_bigend), .st_bufferable(st_bufferable), .wb_enable(wb_enable),
    .align_chk_en(align_chk_en), .cache_hit(cache_hit), .hit_word(hit_word),
    .align_fault(align_fault), .cache_wr_en(cache_wr_en), .cache_wr_idx(cache_wr_idx),
    .cache_wr_data(cache_wr_data), .cache_dirty_first(cache_dirty_first),
    .cache_dirty_last(cache_dirty_last), .wb_push(wb_push), .wb_addr(wb_addr),
    .wb_data(wb_data), .wb_bytes(wb_bytes), .wb_drain_req(wb_drain_req),
    .wb_empty(wb_empty), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_size(mem_size));

  int errors = 0, checks = 0;
  bit done = 0, run_cmp = 0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    pat_mr <= ($urandom_range(0, 2) == 0);
    pat_we <= ($urandom_range(0, 3) == 0);
  end

  // behavioural reference model
  int          phase = 0;
  logic        e_ready = 1, e_fault = 0, e_cwe = 0, e_df = 0, e_dl = 0;
  logic        e_push = 0, e_drain = 0, e_mv = 0;
  logic [2:0]  e_cidx = 0, e_wbytes = 0;
  logic [1:0]  e_msize = 0;
  logic [31:0] e_cdata = 0, e_waddr = 0, e_wdata = 0, e_maddr = 0, e_mdata = 0;

  function automatic logic [31:0] ref_merge(logic [31:0] old, logic [31:0] d,
                                            int sz, bit be, int lo);
    int sh;
    if (sz == 0) begin
      sh = ((be ? 3 : 0) ^ lo) * 8;
      return (old & ~(32'hff << sh)) | ((d & 32'hff) << sh);
    end else if (sz == 1) begin
      sh = ((be ? 2 : 0) ^ (lo & 2)) * 8;
      return (old & ~(32'hffff << sh)) | ((d & 32'hffff) << sh);
    end
    return d;
  endfunction

  always @(posedge clk) begin
    int sz, lo;
    logic [31:0] a;
    if (rst) begin
      phase = 0; e_fault = 0; e_cwe = 0; e_df = 0; e_dl = 0; e_push = 0;
      e_drain = 0; e_mv = 0;
    end else begin
      e_fault = 0; e_cwe = 0; e_df = 0; e_dl = 0; e_push = 0;
      if (phase == 0 && st_valid) begin
        sz = (st_size == 3) ? 2 : int'(st_size);
        lo = int'(st_addr[1:0]);
        a  = st_addr & ~32'd3;
        if (sz == 1) a = a | (st_addr & 32'd2);
        if (sz == 0) a = a | (st_addr & 32'd3);
        if (align_chk_en && lo != 0) e_fault = 1;
        else if (cache_hit) begin
          e_cwe = 1;
          e_cidx = 3'((st_addr >> 2) % 8);
          e_cdata = ref_merge(hit_word, st_data, sz, st_bigend, lo);
          e_df = (e_cidx < 4); e_dl = !(e_cidx < 4);
        end else if (st_bufferable && wb_enable) begin
          e_push = 1; e_waddr = a; e_wdata = st_data;
          e_wbytes = (sz == 0) ? 3'd1 : (sz == 1) ? 3'd2 : 3'd4;
        end else begin
          e_maddr = a; e_mdata = st_data; e_msize = 2'(sz);
          if (st_bufferable) begin phase = 2; e_mv = 1; end
          else begin phase = 1; e_drain = 1; end
        end
      end else if (phase == 1) begin
        if (wb_empty) begin phase = 2; e_drain = 0; e_mv = 1; end
      end else if (phase == 2) begin
        if (mem_ready) begin phase = 0; e_mv = 0; end
      end
    end
    e_ready = (phase == 0);
  end

  always @(negedge clk) begin
    if (run_cmp && !rst) begin
      chk("R9 st_ready", st_ready, e_ready);
      chk("R1 align_fault", align_fault, e_fault);
      chk("R2 cache_wr_en", cache_wr_en, e_cwe);
      chk("R5 dirty", {cache_dirty_first, cache_dirty_last}, {e_df, e_dl});
      if (e_cwe) begin
        chk("R3 R4 cache_wr_data", cache_wr_data, e_cdata);
        chk("R2 cache_wr_idx", cache_wr_idx, e_cidx);
      end
      chk("R6 wb_push", wb_push, e_push);
      if (e_push) chk("R6 wb fields", {wb_addr, wb_data, wb_bytes}, {e_waddr, e_wdata, e_wbytes});
      chk("R8 wb_drain_req", wb_drain_req, e_drain);
      chk("R7 mem_valid", mem_valid, e_mv);
      if (e_mv) chk("R7 mem fields", {mem_addr, mem_data, mem_size}, {e_maddr, e_mdata, e_msize});
    end
  end

  task automatic do_store(logic [31:0] a, logic [31:0] d, logic [1:0] sz, bit be,
                          bit bufb, bit wben, bit hit, logic [31:0] hw, bit chk_en);
    @(negedge clk);
    while (!st_ready) @(negedge clk);
    st_addr = a; st_data = d; st_size = sz; st_bigend = be; st_bufferable = bufb;
    wb_enable = wben; cache_hit = hit; hit_word = hw; align_chk_en = chk_en;
    st_valid = 1;
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 reset ready", st_ready, 1);
    chk("R10 reset outputs", {align_fault, cache_wr_en, cache_dirty_first, cache_dirty_last,
        wb_push, wb_drain_req, mem_valid}, 0);
    run_cmp = 1;

    do_store(32'h0000_0041, 32'hAB, 2'd0, 0, 1, 1, 1, 32'h1122_3344, 0);
    chk("R4 byte little", cache_wr_data, 32'h1122_AB44);
    do_store(32'h0000_0041, 32'hAB, 2'd0, 1, 1, 1, 1, 32'h1122_3344, 0);
    chk("R4 byte big", cache_wr_data, 32'h11AB_3344);
    do_store(32'h0000_0042, 32'hCDEF, 2'd1, 0, 1, 1, 1, 32'h1122_3344, 0);
    chk("R3 half little", cache_wr_data, 32'hCDEF_3344);
    do_store(32'h0000_0042, 32'hCDEF, 2'd1, 1, 1, 1, 1, 32'h1122_3344, 0);
    chk("R3 half big", cache_wr_data, 32'h1122_CDEF);
    do_store(32'h0000_000C, 32'hDEAD_BEEF, 2'd2, 0, 1, 1, 1, 32'h1122_3344, 0);
    chk("R2 word data", cache_wr_data, 32'hDEAD_BEEF);
    chk("R2 word idx", cache_wr_idx, 3);
    chk("R5 idx3 first", {cache_dirty_first, cache_dirty_last}, 2'b10);
    do_store(32'h0000_0010, 32'h1, 2'd3, 0, 1, 1, 1, 32'h0, 0);
    chk("R5 idx4 last", {cache_dirty_first, cache_dirty_last}, 2'b01);
    do_store(32'h0000_1002, 32'h5, 2'd2, 0, 1, 1, 1, 32'h0, 1);
    chk("R1 fault", align_fault, 1);
    chk("R1 no write", {cache_wr_en, wb_push, wb_drain_req, mem_valid}, 0);
    do_store(32'h0000_1003, 32'h77, 2'd1, 0, 1, 1, 0, 32'h0, 0);
    chk("R6 half addr", wb_addr, 32'h1002);
    chk("R6 half bytes", wb_bytes, 2);
    do_store(32'h0000_1003, 32'h77, 2'd0, 0, 1, 1, 0, 32'h0, 0);
    chk("R6 byte addr", wb_addr, 32'h1003);
    do_store(32'h0000_1003, 32'h77, 2'd2, 0, 1, 1, 0, 32'h0, 0);
    chk("R1 R6 word rounded", wb_addr, 32'h1000);
    chk("R6 no mem", mem_valid, 0);

    man_mr = 0;
    do_store(32'h0000_2001, 32'h99, 2'd0, 0, 1, 0, 0, 32'h0, 0);
    chk("R7 direct valid", {mem_valid, wb_drain_req, st_ready}, 3'b100);
    chk("R7 direct addr", mem_addr, 32'h2001);
    @(negedge clk);
    chk("R7 held", mem_valid, 1);
    man_mr = 1;
    @(negedge clk);
    chk("R7 released", {mem_valid, st_ready}, 2'b01);

    man_mr = 0; man_we = 0;
    do_store(32'h0000_3000, 32'h1234, 2'd2, 0, 0, 1, 0, 32'h0, 0);
    chk("R8 drain first", {wb_drain_req, mem_valid, st_ready}, 3'b100);
    @(negedge clk);
    chk("R8 drain waits", {wb_drain_req, mem_valid}, 2'b10);
    man_we = 1;
    @(negedge clk);
    chk("R8 then memory", {wb_drain_req, mem_valid}, 2'b01);
    chk("R8 mem addr", mem_addr, 32'h3000);
    man_mr = 1;
    @(negedge clk);
    chk("R9 ready again", st_ready, 1);

    auto_hs = 1;
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ra;
      ra = $urandom();
      do_store(ra, $urandom(), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), $urandom(), ($urandom_range(0, 3) == 0));
      if ($urandom_range(0, 2) == 0) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule